// File: doc/BRIEF.md
# Interval Metric Predictor with History Table and Voting

This block forecasts the value that a quantized performance metric will take in the next measurement interval. At the end of each interval it receives the measured value of a primary metric and, optionally, the value of a companion metric. The most recent primary values form a history word. That word selects an entry in a small direct-mapped table. Each entry holds a forecast and a vote for every metric, so one history pattern of the primary metric drives forecasts for both metrics.

On every interval strobe the block does two things in the same cycle. It first updates the entry that the old history selected. It then looks up the entry that the new history selects and registers the forecast for the coming interval. An entry that is already present keeps its forecast when the stored forecast agrees with the stored vote. Otherwise the entry takes the new measurement, so a single disagreeing sample cannot overturn a forecast that two observations support. While an entry is still unknown, the block falls back to repeating the last measurement and flags the output as a fallback.

Top module: `hist_vote_predictor`

## Requirements
- R1: While rst_n is low, pred_a, pred_b and pred_hit are 0 and every table entry is marked empty. After reset no entry is found until it has been written again.
- R2: The outputs change only in the cycle after a cycle with meas_valid high. Without meas_valid they hold, whatever meas_a and meas_b do.
- R3: The history word is the last HLEN values of meas_a, with the newest in the low QW bits. The table index is the low AW bits of the history word, and the remaining upper bits are the tag. An entry counts as found only when it is marked present and its tag is equal.
- R4: When the entry for the new history is not found, pred_a and pred_b repeat the meas_a and meas_b of that interval, and pred_hit is 0.
- R5: When the entry for the new history is found, pred_a and pred_b are its stored forecasts, and pred_hit is 1.
- R6: When the entry for the old history is not found, whether it is empty or its tag differs, it is overwritten with the new tag. Forecast and vote of each metric are both set to the measurement.
- R7: When the entry for the old history is found, each metric's new forecast is the most common of three values: the stored vote, the stored forecast and the measurement. When all three differ, the measurement wins.
- R8: After an update of a found entry, its vote field holds the measurement of that interval.
- R9: When the old and new history select the same index, the lookup sees the entry as written in that same cycle.
- R10: With DUAL = 0, pred_b is always 0, and pred_a follows the same rules as with DUAL = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_valid | input | 1 | Interval-end strobe; meas_a and meas_b are valid |
| meas_a | input | QW | Quantized measurement of the primary metric |
| meas_b | input | QW | Quantized measurement of the companion metric |
| pred_a | output | QW | Forecast of the primary metric for the next interval |
| pred_b | output | QW | Forecast of the companion metric (0 when DUAL = 0) |
| pred_hit | output | 1 | 1 when the forecast comes from the table, 0 on fallback |

## Verification
The bench builds the block with QW = 3, HLEN = 2 and AW = 4. This gives a 6-bit history word, a 16-entry table and a 2-bit tag. With these sizes, short value sequences reach every voting outcome. Two histories such as (1,2) and (5,2) share an index and differ only in tag, which makes evictions and tag misses easy to produce. A steady stream of equal values makes the update index and the lookup index coincide. A second instance with DUAL = 0 shares the stimulus, so the single-metric variant is checked against the same expected primary forecasts.

// File: rtl/hvp_pkg.sv
package hvp_pkg;
   localparam int MAX_QW = 8;

   // Most common of three values. When kept and seen agree they form the
   // majority. Otherwise meas is either the majority or the tie-breaker.
   function automatic logic [MAX_QW-1:0] vote3(
      input logic [MAX_QW-1:0] kept,
      input logic [MAX_QW-1:0] seen,
      input logic [MAX_QW-1:0] meas);
      return (kept == seen) ? kept : meas;
   endfunction
endpackage

// File: rtl/hvp_history.sv
module hvp_history #(
   parameter int QW   = 4,
   parameter int HLEN = 4,
   localparam int HW  = QW * HLEN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift,
   input  logic [QW-1:0] din,
   output logic [HW-1:0] hist,
   output logic [HW-1:0] hist_next
);
   logic [HW-1:0] hist_q;

   generate
      if (HLEN == 1) begin : g_one
         assign hist_next = din;
      end else begin : g_many
         assign hist_next = {hist_q[HW-QW-1:0], din};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)     hist_q <= '0;
      else if (shift) hist_q <= hist_next;
   end

   assign hist = hist_q;
endmodule

// File: rtl/hvp_table.sv
module hvp_table #(
   parameter int AW = 6,
   parameter int TW = 10,
   parameter int EW = 8,
   localparam int DEPTH = 1 << AW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [TW-1:0] wtag,
   input  logic [EW-1:0] wpred,
   input  logic [EW-1:0] wvote,
   input  logic [AW-1:0] uaddr,
   output logic          u_valid,
   output logic [TW-1:0] u_tag,
   output logic [EW-1:0] u_pred,
   output logic [EW-1:0] u_vote,
   input  logic [AW-1:0] laddr,
   output logic          l_valid,
   output logic [TW-1:0] l_tag,
   output logic [EW-1:0] l_pred
);
   logic [DEPTH-1:0] valid_q;
   logic [TW-1:0]    tag_q  [DEPTH];
   logic [EW-1:0]    pred_q [DEPTH];
   logic [EW-1:0]    vote_q [DEPTH];
   logic             l_fwd;

   always_ff @(posedge clk) begin
      if (!rst_n)  valid_q <= '0;
      else if (we) valid_q[waddr] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (we) begin
         tag_q[waddr]  <= wtag;
         pred_q[waddr] <= wpred;
         vote_q[waddr] <= wvote;
      end
   end

   // update port: reads the state before this cycle's write
   assign u_valid = valid_q[uaddr];
   assign u_tag   = tag_q[uaddr];
   assign u_pred  = pred_q[uaddr];
   assign u_vote  = vote_q[uaddr];

   // lookup port: sees this cycle's write when the indices match
   assign l_fwd   = we && (laddr == waddr);
   assign l_valid = l_fwd ? 1'b1  : valid_q[laddr];
   assign l_tag   = l_fwd ? wtag  : tag_q[laddr];
   assign l_pred  = l_fwd ? wpred : pred_q[laddr];
endmodule

// File: rtl/hvp_vote.sv
module hvp_vote import hvp_pkg::*; #(
   parameter int QW   = 4,
   parameter int NMET = 2,
   parameter int TW   = 10,
   localparam int EW  = NMET * QW
) (
   input  logic          u_valid,
   input  logic [TW-1:0] u_tag,
   input  logic [TW-1:0] cur_tag,
   input  logic [EW-1:0] u_pred,
   input  logic [EW-1:0] u_vote,
   input  logic [EW-1:0] meas,
   output logic [EW-1:0] wpred,
   output logic [EW-1:0] wvote
);
   logic found;
   assign found = u_valid && (u_tag == cur_tag);

   generate
      for (genvar k = 0; k < NMET; k++) begin : g_met
         logic [MAX_QW-1:0] picked;
         assign picked = vote3(MAX_QW'(u_pred[k*QW +: QW]),
                               MAX_QW'(u_vote[k*QW +: QW]),
                               MAX_QW'(meas[k*QW +: QW]));
         assign wpred[k*QW +: QW] = found ? picked[QW-1:0] : meas[k*QW +: QW];
      end
   endgenerate

   assign wvote = meas;
endmodule

// File: rtl/hist_vote_predictor.sv
module hist_vote_predictor import hvp_pkg::*; #(
   parameter int  QW   = 4,
   parameter int  HLEN = 4,
   parameter int  AW   = 6,
   parameter bit  DUAL = 1'b1,
   localparam int HW   = QW * HLEN,
   localparam int TW   = HW - AW,
   localparam int NMET = DUAL ? 2 : 1,
   localparam int EW   = NMET * QW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          meas_valid,
   input  logic [QW-1:0] meas_a,
   input  logic [QW-1:0] meas_b,
   output logic [QW-1:0] pred_a,
   output logic [QW-1:0] pred_b,
   output logic          pred_hit
);
   generate
      if (QW < 1 || QW > MAX_QW) begin : g_bad_qw
         $error("QW out of range");
      end
      if (HLEN < 1) begin : g_bad_hlen
         $error("HLEN must be at least 1");
      end
      if (AW < 1 || AW >= HW || AW > 12) begin : g_bad_aw
         $error("AW must leave a tag and stay small");
      end
   endgenerate

   logic [HW-1:0] hist_q, hist_nx;
   logic [EW-1:0] meas_vec;
   logic          u_valid, l_valid;
   logic [TW-1:0] u_tag, l_tag;
   logic [EW-1:0] u_pred, u_vote, l_pred, wpred, wvote;
   logic          l_found;
   logic [EW-1:0] pred_q;
   logic          hit_q;

   generate
      if (DUAL) begin : g_dual_in
         assign meas_vec = {meas_b, meas_a};
      end else begin : g_single_in
         assign meas_vec = meas_a;
      end
   endgenerate

   hvp_history #(.QW(QW), .HLEN(HLEN)) u_hist (
      .clk(clk), .rst_n(rst_n), .shift(meas_valid), .din(meas_a),
      .hist(hist_q), .hist_next(hist_nx));

   hvp_table #(.AW(AW), .TW(TW), .EW(EW)) u_tab (
      .clk(clk), .rst_n(rst_n), .we(meas_valid),
      .waddr(hist_q[AW-1:0]), .wtag(hist_q[HW-1:AW]),
      .wpred(wpred), .wvote(wvote),
      .uaddr(hist_q[AW-1:0]), .u_valid(u_valid), .u_tag(u_tag),
      .u_pred(u_pred), .u_vote(u_vote),
      .laddr(hist_nx[AW-1:0]), .l_valid(l_valid), .l_tag(l_tag),
      .l_pred(l_pred));

   hvp_vote #(.QW(QW), .NMET(NMET), .TW(TW)) u_vote_blk (
      .u_valid(u_valid), .u_tag(u_tag), .cur_tag(hist_q[HW-1:AW]),
      .u_pred(u_pred), .u_vote(u_vote), .meas(meas_vec),
      .wpred(wpred), .wvote(wvote));

   assign l_found = l_valid && (l_tag == hist_nx[HW-1:AW]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pred_q <= '0;
         hit_q  <= 1'b0;
      end else if (meas_valid) begin
         pred_q <= l_found ? l_pred : meas_vec;
         hit_q  <= l_found;
      end
   end

   assign pred_a   = pred_q[QW-1:0];
   assign pred_hit = hit_q;

   generate
      if (DUAL) begin : g_dual_out
         assign pred_b = pred_q[2*QW-1:QW];
      end else begin : g_single_out
         assign pred_b = '0;
      end
   endgenerate
endmodule

// File: rtl/hvp_checker.sv
module hvp_checker #(
   parameter int  QW   = 4,
   parameter int  HLEN = 4,
   parameter bit  DUAL = 1'b1,
   localparam int HW   = QW * HLEN
) (
   input logic          clk,
   input logic          rst_n,
   input logic          meas_valid,
   input logic [QW-1:0] meas_a,
   input logic [QW-1:0] meas_b,
   input logic [QW-1:0] pred_a,
   input logic [QW-1:0] pred_b,
   input logic          pred_hit,
   input logic [HW-1:0] hist
);
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_valid |=> ($stable(pred_a) && $stable(pred_b) && $stable(pred_hit)));

   assert_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> (pred_hit ||
         (pred_a == $past(meas_a) && (!DUAL || pred_b == $past(meas_b)))));

   assert_hist_newest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      meas_valid |=> (hist[QW-1:0] == $past(meas_a)));

   assert_hist_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !meas_valid |=> $stable(hist));

   generate
      if (!DUAL) begin : g_single
         assert_b_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
            pred_b == '0);
      end
   endgenerate
endmodule

bind hist_vote_predictor hvp_checker #(.QW(QW), .HLEN(HLEN), .DUAL(DUAL)) u_chk (
   .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_a(meas_a),
   .meas_b(meas_b), .pred_a(pred_a), .pred_b(pred_b), .pred_hit(pred_hit),
   .hist(hist_q));

// File: tb/test_hist_vote_predictor.sv
module test_hist_vote_predictor;
   localparam int QW = 3;
   localparam int NV = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          meas_valid = 1'b0;
   logic [QW-1:0] meas_a = '0, meas_b = '0;
   logic [QW-1:0] pred_a, pred_b, s_pred_a, s_pred_b;
   logic          pred_hit, s_pred_hit;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   hist_vote_predictor #(.QW(QW), .HLEN(2), .AW(4), .DUAL(1'b1)) i_hist_vote_predictor (
      .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_a(meas_a),
      .meas_b(meas_b), .pred_a(pred_a), .pred_b(pred_b), .pred_hit(pred_hit));

   hist_vote_predictor #(.QW(QW), .HLEN(2), .AW(4), .DUAL(1'b0)) i_hist_vote_predictor_single (
      .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_a(meas_a),
      .meas_b(meas_b), .pred_a(s_pred_a), .pred_b(s_pred_b), .pred_hit(s_pred_hit));

   // {meas_a, meas_b, expected pred_a, expected pred_b, expected pred_hit}
   localparam logic [12:0] VEC [NV] = '{
      {3'd1,3'd5, 3'd1,3'd5,1'b0},  // R1 empty table: fallback
      {3'd2,3'd6, 3'd2,3'd6,1'b0},  // R4
      {3'd1,3'd7, 3'd1,3'd7,1'b0},  // R4
      {3'd2,3'd6, 3'd1,3'd7,1'b1},  // R5 history (1,2) found
      {3'd1,3'd4, 3'd2,3'd6,1'b1},  // R7 forecast equals vote: kept
      {3'd2,3'd3, 3'd1,3'd7,1'b1},  // R5
      {3'd3,3'd2, 3'd3,3'd2,1'b0},  // R8 vote of b now 4
      {3'd1,3'd0, 3'd1,3'd0,1'b0},  // R6
      {3'd2,3'd1, 3'd1,3'd2,1'b1},  // R7 all differ -> measured b=2
      {3'd3,3'd5, 3'd1,3'd0,1'b1},  // R7
      {3'd5,3'd5, 3'd5,3'd5,1'b0},  // R4
      {3'd2,3'd1, 3'd2,3'd1,1'b0},  // R3 (5,2) aliases (1,2), tag differs
      {3'd1,3'd6, 3'd2,3'd6,1'b1},  // R6 evicts (1,2)
      {3'd2,3'd4, 3'd2,3'd4,1'b0},  // R6 (1,2) now missing
      {3'd1,3'd0, 3'd2,3'd4,1'b1},  // R7
      {3'd7,3'd3, 3'd7,3'd3,1'b0},  // R4
      {3'd7,3'd2, 3'd7,3'd2,1'b0},  // R9 same index, tag differs
      {3'd7,3'd1, 3'd7,3'd1,1'b1},  // R9 forwarded allocation
      {3'd7,3'd5, 3'd7,3'd1,1'b1},  // R9
      {3'd7,3'd6, 3'd7,3'd6,1'b1}   // R9 forwarded vote result
   };

   function automatic string req_of(int i);
      case (i)
         0: return "R1";  3: return "R5";  4: return "R7";  6: return "R8";
         7: return "R6";  8: return "R7";  11: return "R3"; 12: return "R6";
         13: return "R6"; 16, 17, 18, 19: return "R9";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string req, input string what,
                        input logic [QW-1:0] act, input logic [QW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic step(input logic [QW-1:0] a, input logic [QW-1:0] b);
      @(negedge clk);
      meas_valid = 1'b1;
      meas_a = a;
      meas_b = b;
      @(negedge clk);
      meas_valid = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "pred_a reset", pred_a, 3'd0);
      check("R1", "pred_b reset", pred_b, 3'd0);
      check("R1", "pred_hit reset", {2'b0, pred_hit}, 3'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][12:10], VEC[i][9:7]);
         check(req_of(i), $sformatf("pred_a v%0d", i), pred_a, VEC[i][6:4]);
         check(req_of(i), $sformatf("pred_b v%0d", i), pred_b, VEC[i][3:1]);
         check(req_of(i), $sformatf("pred_hit v%0d", i), {2'b0, pred_hit}, {2'b0, VEC[i][0]});
         check("R10", $sformatf("single pred_a v%0d", i), s_pred_a, VEC[i][6:4]);
         check("R10", $sformatf("single pred_b v%0d", i), s_pred_b, 3'd0);
      end

      // R2: inputs wiggle without a strobe; outputs must hold (7,6,hit)
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         meas_a = 3'(k);
         meas_b = 3'(k + 2);
      end
      @(negedge clk);
      check("R2", "pred_a hold", pred_a, 3'd7);
      check("R2", "pred_b hold", pred_b, 3'd6);
      check("R2", "pred_hit hold", {2'b0, pred_hit}, 3'd1);

      // R1: reset in mid-run clears the outputs and empties the table
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R1", "pred_a re-reset", pred_a, 3'd0);
      check("R1", "pred_hit re-reset", {2'b0, pred_hit}, 3'd0);
      rst_n = 1'b1;
      // History (0,0) is allocated fresh with (0,3) and forwarded (R9).
      // A stale entry from before the reset would give (1,5).
      step(3'd0, 3'd3);
      check("R1", "pred_a after re-reset", pred_a, 3'd0);
      check("R1", "pred_b after re-reset", pred_b, 3'd3);
      check("R9", "pred_hit after re-reset", {2'b0, pred_hit}, 3'd1);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule